// File: doc/BRIEF.md
# Dual-Pixel Colour Sequencer

This block sits at the end of a video fetch path. Video memory delivers two 8-bit pixels at once, one pair per slot. A slot is split into two halves by a phase input. The block turns each pair into a stream of 7-bit colour codes for a resistor-ladder DAC. The colour output is registered, so every change appears one clock after the edge that causes it.

In high-resolution mode both pixels of the pair appear in turn, one per half-slot. In dual-layer mode one pixel of the pair fills the whole slot. The top bit of the second pixel picks that pixel, so it acts as a per-pair layer select. Two mode enables set the owner of the fetch path, and only one of them may be asserted at a time. If neither is asserted, or both are, the processor owns memory. The output then goes black and stays black. A pixel-clock enable can freeze the sequencer for any cycle.

The sequencer is a three-state machine:
- `ST_CPU`: the processor owns memory and the output is black.
- `ST_SLOT_A`: the first half of a slot is showing.
- `ST_SLOT_B`: the second half of a slot is showing.

It has these transitions:
- `go_blank`: from any state to `ST_CPU` whenever the processor owns memory.
- `first_half`: to `ST_SLOT_A` on an advance with phase 0.
- `second_half`: from `ST_SLOT_A` or `ST_SLOT_B` to `ST_SLOT_B` on an advance with phase 1.
- `stall`: every state holds when the pixel clock is withheld.
- `wait_pair`: `ST_CPU` stays in `ST_CPU` on an advance with phase 1.

An advance is a clock edge at which exactly one mode enable is high and `pix_clk_en_i` is high.

Top module: `pixel_pair_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it rises, `colour_o` is 0 (black) until the first advance with phase 0.
- R2: A pair is taken in only on an advance with `phase_i` = 0. Bits [7:0] of `pair_i` form the first pixel and bits [15:8] the second. The held pair stays unchanged until the next such advance.
- R3: In high-resolution mode (`hires_en_i`=1, `dual_en_i`=0), an advance with phase 0 makes `colour_o` equal `pair_i[6:0]` after that edge. A following advance with phase 1 makes `colour_o` equal bits [6:0] of the held second pixel.
- R4: In dual-layer mode (`dual_en_i`=1, `hires_en_i`=0), the pixel shown in both halves is chosen by bit 7 of the second pixel. Bit 7 set shows the second pixel's bits [6:0]. Bit 7 clear shows the first pixel's bits [6:0].
- R5: Bit 7 of the shown pixel never reaches `colour_o`, which carries only bits [6:0].
- R6: With both mode enables low, `colour_o` is 0 after the next edge, whatever `pix_clk_en_i` is.
- R7: With both mode enables high, the block behaves as under R6 and drives black.
- R8: In either video mode with `pix_clk_en_i` = 0, `colour_o` and the held pair do not change.
- R9: After processor ownership or reset, an advance with phase 1 leaves `colour_o` black until a pair has been taken in.
- R10: A mode change between the two halves of a slot applies the new mode to the held pair in the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_i | input | 16 | Pixel pair; [7:0] first pixel, [15:8] second pixel |
| phase_i | input | 1 | Half-slot phase; 0 first half, 1 second half |
| hires_en_i | input | 1 | High-resolution mode enable |
| dual_en_i | input | 1 | Dual-layer mode enable |
| pix_clk_en_i | input | 1 | Pixel clock enable; 0 freezes the sequencer |
| colour_o | output | 7 | Registered colour code for the DAC |

## Verification
Capturing a new pair and handing the bus to the processor can fall on the same edge. So can capturing a pair and switching mode between the two halves. The bench provokes the first by raising or dropping a mode enable on a phase-0 edge. It provokes the second by flipping between the two enables on a phase-1 edge, both in directed steps and in a random stream where the enables change freely. Every cycle is judged against a bench model built from the requirements. In that model, ownership overrides capture, and the second half uses the mode present at its own edge.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [1:0] {
        ST_CPU    = 2'd0,
        ST_SLOT_A = 2'd1,
        ST_SLOT_B = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        OWN_CPU   = 2'd0,
        OWN_HIRES = 2'd1,
        OWN_DUAL  = 2'd2
    } owner_t;

endpackage

// File: rtl/pxs_owner_decode.sv
module pxs_owner_decode
    import pxs_pkg::*;
(
    input  logic   hires_en_i,
    input  logic   dual_en_i,
    output owner_t owner_o
);

    // Exactly one enable selects a video mode; none or both give the bus to the CPU.
    always_comb begin
        unique case ({hires_en_i, dual_en_i})
            2'b10:   owner_o = OWN_HIRES;
            2'b01:   owner_o = OWN_DUAL;
            default: owner_o = OWN_CPU;
        endcase
    end

endmodule

// File: rtl/pxs_pair_hold.sv
module pxs_pair_hold #(
    parameter int PIX_W = 8,
    parameter int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [LANES*PIX_W-1:0]   pair_i,
    output logic [LANES*PIX_W-1:0]   pair_o
);

    // One register per pixel lane, all loaded together.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PIX_W-1:0] lane_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (load_i) begin
                lane_q <= pair_i[g*PIX_W +: PIX_W];
            end
        end

        assign pair_o[g*PIX_W +: PIX_W] = lane_q;
    end

endmodule

// File: rtl/pxs_pixel_pick.sv
module pxs_pixel_pick
    import pxs_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COLOR_W = 7
) (
    input  owner_t             owner_i,
    input  logic               half_i,
    input  logic [PIX_W-1:0]   first_i,
    input  logic [PIX_W-1:0]   second_i,
    output logic [COLOR_W-1:0] colour_o
);

    localparam int SEL_BIT = PIX_W - 1;

    logic [PIX_W-1:0] chosen;

    always_comb begin
        unique case (owner_i)
            OWN_HIRES: chosen = half_i ? second_i : first_i;
            OWN_DUAL:  chosen = second_i[SEL_BIT] ? second_i : first_i;
            default:   chosen = '0;
        endcase
    end

    // The layer/flag bit and anything above the DAC width are dropped.
    assign colour_o = chosen[COLOR_W-1:0];

endmodule

// File: rtl/pixel_pair_sequencer.sv
module pixel_pair_sequencer
    import pxs_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COLOR_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*PIX_W-1:0]     pair_i,
    input  logic                   phase_i,
    input  logic                   hires_en_i,
    input  logic                   dual_en_i,
    input  logic                   pix_clk_en_i,
    output logic [COLOR_W-1:0]     colour_o
);

    localparam int PAIR_W = 2 * PIX_W;

    owner_t             owner;
    seq_state_t         state_q;
    seq_state_t         state_d;
    logic               advance;
    logic               load_pair;
    logic [PAIR_W-1:0]  held_pair;
    logic [COLOR_W-1:0] colour_first;
    logic [COLOR_W-1:0] colour_second;
    logic [COLOR_W-1:0] colour_d;
    logic [COLOR_W-1:0] colour_q;

    pxs_owner_decode u_owner (
        .hires_en_i (hires_en_i),
        .dual_en_i  (dual_en_i),
        .owner_o    (owner)
    );

    assign advance   = (owner != OWN_CPU) && pix_clk_en_i;
    assign load_pair = advance && !phase_i;

    pxs_pair_hold #(
        .PIX_W (PIX_W),
        .LANES (2)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_pair),
        .pair_i (pair_i),
        .pair_o (held_pair)
    );

    // First half is shown straight from the incoming pair.
    pxs_pixel_pick #(
        .PIX_W   (PIX_W),
        .COLOR_W (COLOR_W)
    ) u_pick_first (
        .owner_i  (owner),
        .half_i   (1'b0),
        .first_i  (pair_i[PIX_W-1:0]),
        .second_i (pair_i[PAIR_W-1:PIX_W]),
        .colour_o (colour_first)
    );

    // Second half comes from the held pair under the mode present now.
    pxs_pixel_pick #(
        .PIX_W   (PIX_W),
        .COLOR_W (COLOR_W)
    ) u_pick_second (
        .owner_i  (owner),
        .half_i   (1'b1),
        .first_i  (held_pair[PIX_W-1:0]),
        .second_i (held_pair[PAIR_W-1:PIX_W]),
        .colour_o (colour_second)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CPU: begin
                if (advance && !phase_i) begin
                    state_d = ST_SLOT_A;                       // first_half
                end
            end
            ST_SLOT_A, ST_SLOT_B: begin
                if (advance) begin
                    state_d = phase_i ? ST_SLOT_B : ST_SLOT_A; // second_half / first_half
                end
            end
            default: state_d = ST_CPU;
        endcase
        if (owner == OWN_CPU) begin
            state_d = ST_CPU;                                  // go_blank
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CPU;
        end else begin
            state_q <= state_d;
        end
    end

    // Output selection by destination state
    always_comb begin
        colour_d = colour_q;
        unique case (state_d)
            ST_CPU:    colour_d = '0;
            ST_SLOT_A: colour_d = load_pair ? colour_first : colour_q;
            ST_SLOT_B: colour_d = advance ? colour_second : colour_q;
            default:   colour_d = '0;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            colour_q <= '0;
        end else begin
            colour_q <= colour_d;
        end
    end

    assign colour_o = colour_q;

endmodule

// File: rtl/pxs_seq_checker.sv
module pxs_seq_checker
    import pxs_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COLOR_W = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*PIX_W-1:0]   pair_i,
    input logic                 phase_i,
    input logic                 hires_en_i,
    input logic                 dual_en_i,
    input logic                 pix_clk_en_i,
    input logic [COLOR_W-1:0]   colour_o,
    input seq_state_t           state_q
);

    localparam int SEL_BIT = 2 * PIX_W - 1;

    always_comb begin
        if (!rst_n) begin
            assert_reset_black_R1: assert (colour_o == '0);
        end
    end

    assert_hires_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hires_en_i && !dual_en_i && pix_clk_en_i && !phase_i)
        |=> (colour_o == $past(pair_i[COLOR_W-1:0])));

    assert_dual_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_en_i && !hires_en_i && pix_clk_en_i && !phase_i)
        |=> (colour_o == ($past(pair_i[SEL_BIT]) ? $past(pair_i[PIX_W +: COLOR_W])
                                                 : $past(pair_i[COLOR_W-1:0]))));

    assert_cpu_black_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hires_en_i && !dual_en_i) |=> (colour_o == '0));

    assert_both_black_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hires_en_i && dual_en_i) |=> (colour_o == '0));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hires_en_i ^ dual_en_i) && !pix_clk_en_i) |=> $stable(colour_o));

    assert_wait_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CPU && phase_i) |=> (colour_o == '0));

endmodule

bind pixel_pair_sequencer pxs_seq_checker #(
    .PIX_W   (PIX_W),
    .COLOR_W (COLOR_W)
) u_pxs_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_i       (pair_i),
    .phase_i      (phase_i),
    .hires_en_i   (hires_en_i),
    .dual_en_i    (dual_en_i),
    .pix_clk_en_i (pix_clk_en_i),
    .colour_o     (colour_o),
    .state_q      (state_q)
);

// File: tb/test_pixel_pair_sequencer.sv
`timescale 1ns/1ps
module test_pixel_pair_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pair = '0;
    logic        phase = 1'b0;
    logic        hires = 1'b0;
    logic        dual = 1'b0;
    logic        pen = 1'b0;
    logic [6:0]  colour;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [7:0] m_a = '0;
    logic [7:0] m_b = '0;
    logic       m_live = 1'b0;
    logic [6:0] m_col = '0;

    always #2.5 clk = ~clk;

    pixel_pair_sequencer i_pixel_pair_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair_i       (pair),
        .phase_i      (phase),
        .hires_en_i   (hires),
        .dual_en_i    (dual),
        .pix_clk_en_i (pen),
        .colour_o     (colour)
    );

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: colour actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Model of one edge, derived from the requirements.
    task automatic model_edge(input logic [15:0] p, input logic ph, input logic h,
                              input logic d, input logic en);
        if (h == d) begin
            m_live = 1'b0;
            m_col  = '0;
        end else if (en && !ph) begin
            m_a    = p[7:0];
            m_b    = p[15:8];
            m_live = 1'b1;
            m_col  = h ? p[6:0] : (p[15] ? p[14:8] : p[6:0]);
        end else if (en && ph && m_live) begin
            m_col = h ? m_b[6:0] : (m_b[7] ? m_b[6:0] : m_a[6:0]);
        end
    endtask

    task automatic step(input logic [15:0] p, input logic ph, input logic h,
                        input logic d, input logic en, input string req);
        @(negedge clk);
        pair = p; phase = ph; hires = h; dual = d; pen = en;
        @(posedge clk);
        model_edge(p, ph, h, d, en);
        #1;
        check(req, colour, m_col);
    endtask

    function automatic string tag_of(input logic h, input logic d, input logic en);
        if (h && d)    return "R7";
        if (!h && !d)  return "R6";
        if (!en)       return "R8";
        return h ? "R3" : "R4";
    endfunction

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 check("R1", colour, 7'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check("R1", colour, 7'd0);

        // R9: phase-1 advance with nothing captured stays black
        step(16'h5A3C, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        check("R9", colour, 7'd0);

        // R3 and R5: high-resolution, bit 7 of each pixel dropped
        step(16'hFF80, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        check("R5", colour, 7'h00);
        step(16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
        check("R5", colour, 7'h7F);

        // R4: dual layer, select bit set then clear
        step(16'hC512, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
        check("R4", colour, 7'h45);
        step(16'h1111, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
        check("R4", colour, 7'h45);
        step(16'h45A3, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
        check("R4", colour, 7'h23);
        step(16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
        check("R4", colour, 7'h23);

        // R8 and R2: stall keeps output, and no capture while stalled
        step(16'h1122, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        step(16'h7766, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        check("R8", colour, 7'h22);
        step(16'h7766, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
        check("R2", colour, 7'h11);

        // R10: mode flips between halves; second half uses held pair under new mode
        step(16'h0A3B, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        step(16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        check("R10", colour, 7'h3B);
        step(16'h8A3B, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
        step(16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, "R10");
        check("R10", colour, 7'h0A);

        // R6 / R7: ownership handover on a capture edge, then R9 after it
        step(16'h7F7F, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        check("R6", colour, 7'h00);
        step(16'h7F7F, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        step(16'h7F7F, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
        check("R7", colour, 7'h00);
        step(16'h7F7F, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        check("R9", colour, 7'h00);

        // Random stream, mostly alternating phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] p;
            logic ph, h, d, en;
            int sel;
            p   = 16'($urandom);
            sel = int'($urandom_range(0, 19));
            h   = (sel < 9) || (sel == 19);
            d   = (sel >= 9 && sel < 17) || (sel == 19);
            en  = ($urandom_range(0, 9) != 0);
            ph  = ($urandom_range(0, 7) == 0) ? 1'($urandom) : 1'(i % 2);
            step(p, ph, h, d, en, tag_of(h, d, en));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule